// File: doc/BRIEF.md
# Banked Floating-Point Register Stack

This block is the register storage and stack control of a floating-point coprocessor. It holds four banks of eight 80-bit registers. A 3-bit top pointer addresses each bank as a stack. Requests are push, pop, read of ST(i), write of ST(i), init, top restore and bank select. Every request goes to the bank that is currently active. ST(i) means physical slot (top + i) mod 8. A push first decrements the top pointer and then writes the new ST(0).

Each bank has one tag bit per slot that marks the slot as empty or valid. A bank select comes as a two-byte escape opcode. While it completes, the block holds busy for a fixed number of cycles and ignores requests. Registers in a bank that is not active keep their values. All banks share one top pointer. Values in a bank therefore come back in the correct stack order only after the top pointer is restored, for example from a saved control/status word.

Top module: `fpbank_stack`

## Requirements
- R1: After reset the active bank is 0, top is 0, busy, rd_valid and fault are low, and every tag of every bank is empty.
- R2: A bank select with esc_op = 16'hDBE8, 16'hDBEB, 16'hDBEA or 16'hDBE9 makes bank 0, 1, 2 or 3 active. The high byte is the escape prefix. The bank output shows the new bank in the cycle after the request.
- R3: A bank select with any other esc_op value has no effect: the bank does not change and busy stays low.
- R4: An accepted bank select drives busy high for exactly 6 cycles, starting the cycle after the request. Any request presented while busy is high is ignored.
- R5: A push (cmd_kind 1) whose target slot (top-1) mod 8 is empty writes cmd_data into that slot, marks the slot valid and sets top to (top-1) mod 8.
- R6: A pop (cmd_kind 2) of a valid ST(0) returns the stored value on rd_data with rd_valid high in the next cycle, marks the slot empty and sets top to (top+1) mod 8.
- R7: A read (cmd_kind 3) returns slot (top+cmd_idx) mod 8 on rd_data in the next cycle and changes nothing. A write (cmd_kind 4) replaces that slot and marks it valid.
- R8: The registers of a bank keep their values while other banks are active.
- R9: Top is shared by all banks and does not change on a bank select. A set-top request (cmd_kind 6) loads top from cmd_idx.
- R10: An init request (cmd_kind 5) empties every tag of the active bank and clears top to 0. It does not touch the data or tags of other banks.
- R11: A push to a valid slot or a pop from an empty slot raises fault for one cycle. It changes no register, tag or top value and raises no rd_valid.
- R12: Bank 3, the scratchpad bank, accepts every request the same way as the other banks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Request strobe |
| cmd_kind | input | 3 | 0 none, 1 push, 2 pop, 3 read, 4 write, 5 init, 6 set top, 7 bank select |
| cmd_idx | input | 3 | Stack index i for read/write; new top value for set top |
| cmd_data | input | 80 | Data for push and write |
| esc_op | input | 16 | Two-byte opcode for bank select |
| busy | output | 1 | Bank switch in progress; requests ignored |
| bank | output | 2 | Active bank |
| top | output | 3 | Shared top-of-stack pointer |
| rd_valid | output | 1 | rd_data holds a pop or read result |
| rd_data | output | 80 | Read data |
| fault | output | 1 | One-cycle stack fault pulse |

## Verification
A wrong active-bank register shows up at the bank port one cycle after the select. If the bank is right but the data lands in the wrong storage, the error appears later, when a read after returning to a bank gives a value from a different bank. A corrupted tag stays hidden until a push or pop reaches that slot: it then raises a false fault or misses one, and the top pointer freezes or moves wrongly in that same cycle. A busy counter that is off by one is caught by counting busy cycles and by a request sent during the hold that must leave top unchanged.

// File: rtl/fpbank_pkg.sv
package fpbank_pkg;

    typedef enum logic [2:0] {
        CMD_NONE   = 3'd0,
        CMD_PUSH   = 3'd1,
        CMD_POP    = 3'd2,
        CMD_READ   = 3'd3,
        CMD_WRITE  = 3'd4,
        CMD_INIT   = 3'd5,
        CMD_SETTOP = 3'd6,
        CMD_BANK   = 3'd7
    } cmd_e;

    localparam logic [7:0] ESC_PREFIX = 8'hDB;

endpackage

// File: rtl/fpbank_decode.sv
module fpbank_decode #(
    parameter int BANK_W = 2
) (
    input  logic [15:0]       esc_op,
    output logic              sel_hit,
    output logic [BANK_W-1:0] sel_bank
);
    import fpbank_pkg::*;

    always_comb begin
        sel_hit  = 1'b0;
        sel_bank = '0;
        if (esc_op[15:8] == ESC_PREFIX) begin
            case (esc_op[7:0])
                8'hE8: begin sel_hit = 1'b1; sel_bank = BANK_W'(0); end
                8'hEB: begin sel_hit = 1'b1; sel_bank = BANK_W'(1); end
                8'hEA: begin sel_hit = 1'b1; sel_bank = BANK_W'(2); end
                8'hE9: begin sel_hit = 1'b1; sel_bank = BANK_W'(3); end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/fpbank_regfile.sv
module fpbank_regfile #(
    parameter int BANKS = 4,
    parameter int DEPTH = 8,
    parameter int WIDTH = 80
) (
    input  logic                                    clk,
    input  logic                                    we,
    input  logic [$clog2(BANKS)+$clog2(DEPTH)-1:0]  addr,
    input  logic [WIDTH-1:0]                        wdata,
    output logic [WIDTH-1:0]                        rdata
);
    localparam int AW      = $clog2(BANKS) + $clog2(DEPTH);
    localparam int ENTRIES = BANKS * DEPTH;

    logic [WIDTH-1:0] mem_q [ENTRIES];

    genvar g;
    generate
        for (g = 0; g < ENTRIES; g++) begin : g_entry
            logic [WIDTH-1:0] ent_d;
            always_comb begin
                ent_d = mem_q[g];
                if (we && addr == AW'(g)) ent_d = wdata;
            end
            always_ff @(posedge clk) mem_q[g] <= ent_d;
        end
    endgenerate

    assign rdata = mem_q[addr];
endmodule

// File: rtl/fpbank_tags.sv
module fpbank_tags #(
    parameter int BANKS = 4,
    parameter int DEPTH = 8
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    set_en,
    input  logic                                    clr_en,
    input  logic [$clog2(BANKS)+$clog2(DEPTH)-1:0]  addr,
    input  logic                                    wipe_en,
    input  logic [$clog2(BANKS)-1:0]                wipe_bank,
    output logic [BANKS*DEPTH-1:0]                  tag_vec
);
    localparam int SW      = $clog2(DEPTH);
    localparam int ENTRIES = BANKS * DEPTH;

    logic [ENTRIES-1:0] tag_d, tag_q;

    always_comb begin
        tag_d = tag_q;
        if (set_en) tag_d[addr] = 1'b1;
        if (clr_en) tag_d[addr] = 1'b0;
        if (wipe_en) begin
            for (int s = 0; s < DEPTH; s++) tag_d[{wipe_bank, SW'(s)}] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tag_q <= '0;
        else        tag_q <= tag_d;
    end

    assign tag_vec = tag_q;

    AST_WIPE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n) wipe_en |=> (tag_q[{$past(wipe_bank), {SW{1'b0}}} +: DEPTH] == '0)); // R10
    AST_SET_MARKS: assert property (@(posedge clk) disable iff (!rst_n) (set_en && !wipe_en) |=> tag_q[$past(addr)]); // R5
    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n) clr_en |=> !tag_q[$past(addr)]); // R6
endmodule

// File: rtl/fpbank_stack.sv
module fpbank_stack #(
    parameter int BANKS      = 4,
    parameter int DEPTH      = 8,
    parameter int WIDTH      = 80,
    parameter int SEL_CYCLES = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cmd_valid,
    input  logic [2:0]                  cmd_kind,
    input  logic [$clog2(DEPTH)-1:0]    cmd_idx,
    input  logic [WIDTH-1:0]            cmd_data,
    input  logic [15:0]                 esc_op,
    output logic                        busy,
    output logic [$clog2(BANKS)-1:0]    bank,
    output logic [$clog2(DEPTH)-1:0]    top,
    output logic                        rd_valid,
    output logic [WIDTH-1:0]            rd_data,
    output logic                        fault
);
    import fpbank_pkg::*;

    localparam int BW = $clog2(BANKS);
    localparam int SW = $clog2(DEPTH);
    localparam int AW = BW + SW;
    localparam int CW = $clog2(SEL_CYCLES + 1);

    typedef struct packed {
        logic [BW-1:0]    bank;
        logic [SW-1:0]    top;
        logic [CW-1:0]    cnt;
        logic             rd_valid;
        logic [WIDTH-1:0] rd_data;
        logic             fault;
    } state_t;

    state_t st_d, st_q;

    cmd_e             kind;
    logic             go;
    logic             sel_hit;
    logic [BW-1:0]    sel_bank;
    logic [SW-1:0]    slot;
    logic [AW-1:0]    addr;
    logic [WIDTH-1:0] rdata;
    logic [BANKS*DEPTH-1:0] tag_vec;
    logic             slot_valid;
    logic             we, tag_set, tag_clr, wipe;

    assign kind = cmd_e'(cmd_kind);
    assign go   = cmd_valid && (st_q.cnt == '0);

    fpbank_decode #(.BANK_W(BW)) u_decode (
        .esc_op   (esc_op),
        .sel_hit  (sel_hit),
        .sel_bank (sel_bank)
    );

    always_comb begin
        case (kind)
            CMD_PUSH:            slot = st_q.top - SW'(1);
            CMD_READ, CMD_WRITE: slot = st_q.top + cmd_idx;
            default:             slot = st_q.top;
        endcase
    end

    assign addr       = {st_q.bank, slot};
    assign slot_valid = tag_vec[addr];

    fpbank_regfile #(.BANKS(BANKS), .DEPTH(DEPTH), .WIDTH(WIDTH)) u_regfile (
        .clk   (clk),
        .we    (we),
        .addr  (addr),
        .wdata (cmd_data),
        .rdata (rdata)
    );

    fpbank_tags #(.BANKS(BANKS), .DEPTH(DEPTH)) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_en    (tag_set),
        .clr_en    (tag_clr),
        .addr      (addr),
        .wipe_en   (wipe),
        .wipe_bank (st_q.bank),
        .tag_vec   (tag_vec)
    );

    always_comb begin
        st_d          = st_q;
        st_d.rd_valid = 1'b0;
        st_d.fault    = 1'b0;
        we            = 1'b0;
        tag_set       = 1'b0;
        tag_clr       = 1'b0;
        wipe          = 1'b0;
        if (st_q.cnt != '0) st_d.cnt = st_q.cnt - CW'(1);
        if (go) begin
            case (kind)
                CMD_PUSH: begin
                    if (slot_valid) st_d.fault = 1'b1;
                    else begin
                        we       = 1'b1;
                        tag_set  = 1'b1;
                        st_d.top = slot;
                    end
                end
                CMD_POP: begin
                    if (!slot_valid) st_d.fault = 1'b1;
                    else begin
                        tag_clr       = 1'b1;
                        st_d.rd_valid = 1'b1;
                        st_d.rd_data  = rdata;
                        st_d.top      = st_q.top + SW'(1);
                    end
                end
                CMD_READ: begin
                    st_d.rd_valid = 1'b1;
                    st_d.rd_data  = rdata;
                end
                CMD_WRITE: begin
                    we      = 1'b1;
                    tag_set = 1'b1;
                end
                CMD_INIT: begin
                    wipe     = 1'b1;
                    st_d.top = '0;
                end
                CMD_SETTOP: st_d.top = cmd_idx;
                CMD_BANK: begin
                    if (sel_hit) begin
                        st_d.bank = sel_bank;
                        st_d.cnt  = CW'(SEL_CYCLES);
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.bank     <= '0;
            st_q.top      <= '0;
            st_q.cnt      <= '0;
            st_q.rd_valid <= 1'b0;
            st_q.rd_data  <= '0;
            st_q.fault    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy     = (st_q.cnt != '0);
    assign bank     = st_q.bank;
    assign top      = st_q.top;
    assign rd_valid = st_q.rd_valid;
    assign rd_data  = st_q.rd_data;
    assign fault    = st_q.fault;

    AST_SEL_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (go && kind == CMD_BANK && sel_hit) |=> busy); // R4
    AST_BUSY_FREEZES: assert property (@(posedge clk) disable iff (!rst_n) busy |=> ($stable(top) && !rd_valid && !fault)); // R4
    AST_BANK_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n) !$stable(bank) |-> $past(cmd_valid && cmd_kind == 3'd7)); // R3
    AST_FAULT_KEEPS_TOP: assert property (@(posedge clk) disable iff (!rst_n) fault |-> ($stable(top) && !rd_valid)); // R11
    AST_SEL_KEEPS_TOP: assert property (@(posedge clk) disable iff (!rst_n) (go && kind == CMD_BANK) |=> $stable(top)); // R9
endmodule

// File: tb/fpbank_stack_bench.sv
module fpbank_stack_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_kind = 3'd0;
    logic [2:0]  cmd_idx = 3'd0;
    logic [79:0] cmd_data = '0;
    logic [15:0] esc_op = '0;
    logic        busy;
    logic [1:0]  bank;
    logic [2:0]  top;
    logic        rd_valid;
    logic [79:0] rd_data;
    logic        fault;

    int errors = 0;
    int checks = 0;
    logic [79:0] exp_q[$];
    string       req_q[$];

    always #10 clk = ~clk;

    fpbank_stack u_fpbank_stack (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_idx(cmd_idx), .cmd_data(cmd_data), .esc_op(esc_op), .busy(busy),
        .bank(bank), .top(top), .rd_valid(rd_valid), .rd_data(rd_data), .fault(fault)
    );

    localparam logic [79:0] A1 = 80'h3FFF_8000_0000_0000_0001;
    localparam logic [79:0] A2 = 80'h4000_C000_0000_0000_0002;
    localparam logic [79:0] A3 = 80'h4001_A000_0000_0000_0003;
    localparam logic [79:0] B1 = 80'hC002_9000_0000_0000_00B1;
    localparam logic [79:0] C1 = 80'h1234_5678_9ABC_DEF0_00C1;
    localparam logic [79:0] C2 = 80'h0FED_CBA9_8765_4321_00C2;
    localparam logic [79:0] C3 = 80'h7FFF_FFFF_0000_FFFF_00C3;

    task automatic chk(input string req, input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] k, input logic [2:0] i,
                         input logic [79:0] d, input logic [15:0] e);
        cmd_valid = 1'b1; cmd_kind = k; cmd_idx = i; cmd_data = d; esc_op = e;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_kind = 3'd0;
    endtask

    task automatic expect_rd(input string req, input logic [79:0] d);
        exp_q.push_back(d);
        req_q.push_back(req);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    // Scoreboard monitor: each rd_valid pulse pops one expected item
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R6/R7 unexpected rd_valid actual=%0h expected=none", rd_data);
            end else begin
                chk(req_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 bank", 80'(bank), 80'd0);
        chk("R1 top", 80'(top), 80'd0);
        chk("R1 busy", 80'(busy), 80'd0);
        chk("R1 fault", 80'(fault), 80'd0);
        issue(3'd2, 3'd0, '0, '0);
        chk("R1 empty tags pop faults", 80'(fault), 80'd1);

        // R5 push with wrap
        issue(3'd1, 3'd0, A1, '0);
        chk("R5 top wraps to 7", 80'(top), 80'd7);
        issue(3'd1, 3'd0, A2, '0);
        issue(3'd1, 3'd0, A3, '0);
        chk("R5 top after three pushes", 80'(top), 80'd5);
        expect_rd("R7 read ST0", A3);
        issue(3'd3, 3'd0, '0, '0);
        expect_rd("R7 read ST2", A1);
        issue(3'd3, 3'd2, '0, '0);

        // R4 select bank 1, count busy, request during busy ignored
        issue(3'd7, 3'd0, '0, 16'hDBEB);
        chk("R2 bank1 select", 80'(bank), 80'd1);
        n = 0;
        while (busy && n < 20) begin
            n++;
            if (n == 1) begin
                cmd_valid = 1'b1; cmd_kind = 3'd1; cmd_data = C1;
            end
            @(negedge clk);
            cmd_valid = 1'b0; cmd_kind = 3'd0;
        end
        chk("R4 busy length", 80'(n), 80'd6);
        chk("R4 push during busy ignored", 80'(top), 80'd5);
        chk("R9 top shared across select", 80'(top), 80'd5);

        // R10 init in bank 1
        issue(3'd5, 3'd0, '0, '0);
        chk("R10 init clears top", 80'(top), 80'd0);
        issue(3'd1, 3'd0, B1, '0);
        chk("R10 push after init no fault", 80'(fault), 80'd0);
        expect_rd("R5 bank1 ST0", B1);
        issue(3'd3, 3'd0, '0, '0);

        // R8/R9 back to bank 0, restore top
        issue(3'd7, 3'd0, '0, 16'hDBE8);
        wait_idle();
        chk("R2 bank0 select", 80'(bank), 80'd0);
        chk("R9 top kept on select", 80'(top), 80'd7);
        issue(3'd6, 3'd5, '0, '0);
        chk("R9 set top", 80'(top), 80'd5);
        expect_rd("R8 bank0 ST0 persists", A3);
        issue(3'd3, 3'd0, '0, '0);
        expect_rd("R10 other bank untouched by init", A2);
        issue(3'd3, 3'd1, '0, '0);

        // R3 unknown escapes
        issue(3'd7, 3'd0, '0, 16'hDBEC);
        chk("R3 unknown code no busy", 80'(busy), 80'd0);
        chk("R3 unknown code bank kept", 80'(bank), 80'd0);
        issue(3'd7, 3'd0, '0, 16'h00E8);
        chk("R3 wrong prefix no busy", 80'(busy), 80'd0);

        // R8 bank 1 data persists
        issue(3'd7, 3'd0, '0, 16'hDBEB);
        wait_idle();
        issue(3'd6, 3'd7, '0, '0);
        expect_rd("R8 bank1 ST0 persists", B1);
        issue(3'd3, 3'd0, '0, '0);

        // R2/R12 banks 2 and 3
        issue(3'd7, 3'd0, '0, 16'hDBEA);
        chk("R2 bank2 select", 80'(bank), 80'd2);
        wait_idle();
        issue(3'd7, 3'd0, '0, 16'hDBE9);
        chk("R12 bank3 select", 80'(bank), 80'd3);
        wait_idle();
        issue(3'd5, 3'd0, '0, '0);
        issue(3'd1, 3'd0, C1, '0);
        chk("R12 push in bank3", 80'(top), 80'd7);
        issue(3'd4, 3'd1, C3, '0);
        issue(3'd4, 3'd0, C2, '0);
        expect_rd("R7 write ST1 then read", C3);
        issue(3'd3, 3'd1, '0, '0);
        expect_rd("R6 pop returns rewritten ST0", C2);
        issue(3'd2, 3'd0, '0, '0);
        chk("R6 pop increments top", 80'(top), 80'd0);

        // R11 faults
        issue(3'd6, 3'd1, '0, '0);
        issue(3'd1, 3'd0, A1, '0);
        chk("R11 push to valid slot faults", 80'(fault), 80'd1);
        chk("R11 push fault keeps top", 80'(top), 80'd1);
        expect_rd("R11 slot unchanged after fault", C3);
        issue(3'd3, 3'd7, '0, '0);
        issue(3'd6, 3'd3, '0, '0);
        issue(3'd2, 3'd0, '0, '0);
        chk("R11 pop empty faults", 80'(fault), 80'd1);
        chk("R11 pop fault keeps top", 80'(top), 80'd3);

        repeat (2) @(negedge clk);
        chk("R6 all expected reads seen", 80'(exp_q.size()), 80'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule